// File: doc/BRIEF.md
# Four-Lane Alignment-Start Deskew Buffer

This block lines up four parallel receive lanes of a multi-lane serial link whose data arrives with different latencies. Every lane delivers one 32-bit word per clock. A word holds four octets, and each octet has its own control flag. Each lane watches for the octet that opens its initial lane alignment sequence. From that octet onward the lane re-packs its stream so that the opening octet sits in octet 0 of a word, and it writes the re-packed words into a private 16-entry elastic buffer.

No buffer is read while any lane is still waiting for its opening octet. Once the last lane has seen it, all four buffers begin reading on the same clock. Their outputs therefore present the same word of the sequence on every lane, and a sticky aligned flag goes high. If the lanes do not all report within a programmable window after the first one, the block pulses a re-initialization request for one cycle. That pulse clears every lane and every buffer so the lanes can try again. A lane that has to store more words than its buffer holds while it waits for a lagging lane raises its own sticky overflow flag.

Top module: `lane_deskew`

## Requirements
- R1: Lane l carries a word on `rx_data[l*32 +: 32]` each clock, with octet o at bits `[o*8 +: 8]` (octet 0 first in time) and its control flag at `rx_ctrl[l*4+o]`; outputs use the same layout.
- R2: A lane's start is the first octet equal to 0x1C whose control flag is 1, at any octet position; a 0x1C with flag 0 does not count. Octets before it are discarded. Stored words begin with the start octet in octet 0 and continue in stream order. Later start octets on an armed lane pass through as data.
- R3: While any lane has not seen its start octet, `out_valid` and `aligned` stay 0.
- R4: If the last lane's start octet is sampled at clock edge T, then `out_valid` and `aligned` are first 1 after edge T+2. From then on, every lane presents word j of its own re-packed stream on the j-th valid cycle, with no gaps.
- R5: `aligned` stays 1 until reset or a re-initialization.
- R6: Each lane buffer has 16 entries. A lane that sees its start up to 15 words before the last lane does not overflow, and its data stays intact.
- R7: A lane that sees its start 16 or more words before the last lane sets its bit of `overflow`. The bit is sticky, and the other lanes' bits stay 0.
- R8: If the first start octet is sampled at edge E and not every lane has seen its start by edge E+TIMEOUT_CYC-1 (default 64), `reinit_req` is 1 for exactly the one cycle after edge E+TIMEOUT_CYC. If every lane reports by that edge, no request is issued.
- R9: A re-initialization clears the lanes, buffers, `overflow` and `aligned` on the next edge, and the lanes re-arm and can align again without a reset.
- R10: After a synchronous reset, `out_valid`, `aligned`, `reinit_req` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 128 | Incoming words, 32 bits per lane |
| rx_ctrl | input | 16 | Per-octet control flags, 4 per lane |
| out_data | output | 128 | Deskewed words, 32 bits per lane |
| out_ctrl | output | 16 | Per-octet control flags of the deskewed words |
| out_valid | output | 1 | Deskewed words valid |
| aligned | output | 1 | Lanes released together (sticky) |
| reinit_req | output | 1 | One-cycle re-initialization request on timeout |
| overflow | output | 4 | Sticky per-lane buffer overflow |

## Verification
The hardest situations to reach are the edges of the two windows. The first is a lane that starts exactly 15 or exactly 16 words ahead of the last lane, where the buffer is either just full or forced to drop a word. The second is a last lane that reports on the final edge of the timeout window. The bench builds every lane's octet stream from a start position it chooses, so it places each lane's start octet on an exact edge and at an exact octet offset. This lets it steer straight onto those boundaries and also sweep random skews and offsets. A timeout run with three silent lanes first overflows the early lane, then triggers the request, and is followed by a fresh alignment without reset to show that the lanes re-arm.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;
  localparam int unsigned OCT_BITS = 8;
  localparam logic [7:0]  START_OCTET = 8'h1C;
endpackage

// File: rtl/deskew_lane_front.sv
module deskew_lane_front
  import lane_deskew_pkg::*;
#(
  parameter int OCTETS = 4,
  localparam int W  = OCTETS * OCT_BITS,
  localparam int OW = (OCTETS > 1) ? $clog2(OCTETS) : 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [W-1:0]      in_data,
  input  logic [OCTETS-1:0] in_ctrl,
  output logic              started,
  output logic              wr_en,
  output logic [W-1:0]      wr_data,
  output logic [OCTETS-1:0] wr_ctrl
);
  logic [W-1:0]      hold_data;
  logic [OCTETS-1:0] hold_ctrl;
  logic [OW-1:0]     off_q, hit_pos;
  logic              hit;

  // lowest octet position carrying a flagged start octet
  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    for (int k = OCTETS - 1; k >= 0; k--) begin
      if (in_ctrl[k] && in_data[k*OCT_BITS +: OCT_BITS] == START_OCTET) begin
        hit     = 1'b1;
        hit_pos = OW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    hold_data <= in_data;
    hold_ctrl <= in_ctrl;
    if (clr) begin
      started <= 1'b0;
      off_q   <= '0;
    end else if (!started && hit) begin
      started <= 1'b1;
      off_q   <= hit_pos;
    end
  end

  // re-pack: octets off..N-1 of previous word, then 0..off-1 of current
  always_comb begin
    for (int o = 0; o < OCTETS; o++) begin
      int idx;
      idx = int'(off_q) + o;
      if (idx < OCTETS) begin
        wr_data[o*OCT_BITS +: OCT_BITS] = hold_data[idx*OCT_BITS +: OCT_BITS];
        wr_ctrl[o] = hold_ctrl[idx];
      end else begin
        wr_data[o*OCT_BITS +: OCT_BITS] = in_data[(idx-OCTETS)*OCT_BITS +: OCT_BITS];
        wr_ctrl[o] = in_ctrl[idx-OCTETS];
      end
    end
  end

  assign wr_en = started;

  p_start_hold_r2: assert property (@(posedge clk) disable iff (clr)
    started |=> started);
endmodule

// File: rtl/deskew_fifo.sv
module deskew_fifo #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             ovf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             full, do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign do_rd = rd_en && (count != '0);
  assign do_wr = wr_en && (!full || do_rd);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
      if (wr_en && !do_wr) ovf <= 1'b1;
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf);
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl #(
  parameter int NUM_LANES   = 4,
  parameter int TIMEOUT_CYC = 64,
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] started,
  output logic                 clr,
  output logic                 rel,
  output logic                 out_valid,
  output logic                 aligned,
  output logic                 reinit_req
);
  logic          all_in, partial, fire;
  logic [TW-1:0] tmo_cnt;

  assign all_in  = &started;
  assign partial = (|started) && !all_in;
  assign fire    = partial && (tmo_cnt == TW'(TIMEOUT_CYC - 1));
  assign clr     = rst || reinit_req;

  always_ff @(posedge clk) begin
    if (rst) reinit_req <= 1'b0;
    else     reinit_req <= fire;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      tmo_cnt   <= '0;
      rel       <= 1'b0;
      out_valid <= 1'b0;
      aligned   <= 1'b0;
    end else begin
      tmo_cnt   <= (partial && !fire) ? tmo_cnt + 1'b1 : '0;
      rel       <= all_in;
      out_valid <= rel;
      if (rel) aligned <= 1'b1;
    end
  end

  p_release_all_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(all_in, 2));
  p_aligned_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (aligned && !clr) |=> aligned);
  p_reinit_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    reinit_req |=> !reinit_req);
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import lane_deskew_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int OCTETS      = 4,
  parameter int DEPTH       = 16,
  parameter int TIMEOUT_CYC = 64,
  localparam int W = OCTETS * OCT_BITS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LANES*W-1:0]      rx_data,
  input  logic [NUM_LANES*OCTETS-1:0] rx_ctrl,
  output logic [NUM_LANES*W-1:0]      out_data,
  output logic [NUM_LANES*OCTETS-1:0] out_ctrl,
  output logic                        out_valid,
  output logic                        aligned,
  output logic                        reinit_req,
  output logic [NUM_LANES-1:0]        overflow
);
  logic                 clr, rel;
  logic [NUM_LANES-1:0] started;

  deskew_ctrl #(.NUM_LANES(NUM_LANES), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .started(started), .clr(clr), .rel(rel),
    .out_valid(out_valid), .aligned(aligned), .reinit_req(reinit_req));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic              wr_en;
    logic [W-1:0]      wr_data;
    logic [OCTETS-1:0] wr_ctrl;

    deskew_lane_front #(.OCTETS(OCTETS)) u_front (
      .clk(clk), .clr(clr),
      .in_data(rx_data[l*W +: W]), .in_ctrl(rx_ctrl[l*OCTETS +: OCTETS]),
      .started(started[l]), .wr_en(wr_en), .wr_data(wr_data), .wr_ctrl(wr_ctrl));

    deskew_fifo #(.WIDTH(W + OCTETS), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en),
      .wr_data({wr_ctrl, wr_data}), .rd_en(rel),
      .rd_data({out_ctrl[l*OCTETS +: OCTETS], out_data[l*W +: W]}),
      .ovf(overflow[l]));
  end

  p_valid_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> aligned);
endmodule

// File: tb/lane_deskew_tb.sv
module lane_deskew_tb;
  localparam int NL = 4, NO = 4, W = 32, TMO = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic [NL*W-1:0]  rx_data = '0, out_data;
  logic [NL*NO-1:0] rx_ctrl = '0, out_ctrl;
  logic out_valid, aligned, reinit_req;
  logic [NL-1:0] overflow;

  lane_deskew #(.NUM_LANES(NL), .OCTETS(NO), .DEPTH(16), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid),
    .aligned(aligned), .reinit_req(reinit_req), .overflow(overflow));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int start_b [NL];
  int unsigned seed = 32'h1234_5678;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // octet stream of lane l at byte position b: {flag, value}
  function automatic logic [8:0] gen_byte(int l, int b);
    int k;
    if (start_b[l] < 0 || b < start_b[l])
      return (b % 2 == 0) ? {1'b0, 8'h1C} : {1'b1, 8'hBC};
    k = b - start_b[l];
    if (k == 0) return {1'b1, 8'h1C};
    if (k == 9) return {1'b1, 8'h1C};
    return {(k % 7 == 0), 8'(k * 3 + l * 64 + 5)};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 0 && aligned == 0 && reinit_req == 0 && overflow == 0,
        "R10", "reset state", {out_valid, aligned, reinit_req, overflow}, 0);
  endtask

  // iteration c observes state after edge c-1, then drives word c (sampled at edge c)
  task automatic run(int ncyc, bit chk_align, bit chk_data, int tmo_e, logic [NL-1:0] exp_ovf);
    int clast = 0;
    bit bad_reinit = 0;
    for (int l = 0; l < NL; l++) if (start_b[l] / 4 > clast) clast = start_b[l] / 4;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (reinit_req && (tmo_e < 0 || c != tmo_e + TMO + 1)) bad_reinit = 1;
      if (chk_align) begin
        if (c == clast + 2)
          chk(aligned == 0 && out_valid == 0, "R3", "held before release",
              {aligned, out_valid}, 0);
        if (c == clast + 3)
          chk(aligned == 1 && out_valid == 1, "R4", "release timing",
              {aligned, out_valid}, 3);
        if (c > clast + 3 && c == ncyc - 1)
          chk(aligned == 1, "R5", "aligned held", aligned, 1);
        if (chk_data && c >= clast + 3 && c < clast + 13) begin
          for (int l = 0; l < NL; l++) begin
            logic [W-1:0] ed;
            logic [NO-1:0] ec;
            for (int o = 0; o < NO; o++)
              {ec[o], ed[o*8 +: 8]} = gen_byte(l, start_b[l] + 4 * (c - clast - 3) + o);
            chk(out_data[l*W +: W] == ed && out_ctrl[l*NO +: NO] == ec,
                (c == clast + 3) ? "R2" : "R1", $sformatf("lane %0d word %0d", l, c - clast - 3),
                {out_ctrl[l*NO +: NO], out_data[l*W +: W]}, {ec, ed});
          end
        end
      end
      if (tmo_e >= 0) begin
        if (c == tmo_e + TMO) begin
          chk(reinit_req == 0, "R8", "no request before window end", reinit_req, 0);
          chk(overflow == exp_ovf, "R7", "overflow while waiting", overflow, exp_ovf);
        end
        if (c == tmo_e + TMO + 1)
          chk(reinit_req == 1, "R8", "timeout request", reinit_req, 1);
        if (c == tmo_e + TMO + 2) begin
          chk(reinit_req == 0, "R8", "request is one cycle", reinit_req, 0);
          chk(overflow == 0 && aligned == 0, "R9", "cleared by reinit",
              {overflow, aligned}, 0);
        end
      end
      if (chk_align && c == ncyc - 1)
        chk(overflow == exp_ovf, (exp_ovf != 0) ? "R7" : "R6", "overflow flags", overflow, exp_ovf);
      for (int l = 0; l < NL; l++)
        for (int o = 0; o < NO; o++)
          {rx_ctrl[l*NO + o], rx_data[l*W + o*8 +: 8]} = gen_byte(l, 4 * c + o);
    end
    chk(!bad_reinit, "R8", "no unexpected request", bad_reinit, 0);
  endtask

  function automatic int rnd(int m);
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 8) % m);
  endfunction

  initial begin
    do_reset();
    // R4 sweep: random skew 0..10 words and octet offset 0..3 per lane
    for (int r = 0; r < 12; r++) begin
      int mx = 0;
      for (int l = 0; l < NL; l++) begin
        start_b[l] = 4 * (2 + rnd(11)) + ((r < 4) ? r : rnd(4));
        if (start_b[l] / 4 > mx) mx = start_b[l] / 4;
      end
      do_reset();
      run(mx + 16, 1, 1, -1, '0);
    end
    // R6 boundary: lane 0 leads by 15 words
    start_b[0] = 8 + 1;
    for (int l = 1; l < NL; l++) start_b[l] = 4 * 17 + 3;
    do_reset();
    run(17 + 16, 1, 1, -1, 4'b0000);
    // R7 boundary: lane 2 leads by 16 words
    for (int l = 0; l < NL; l++) start_b[l] = 4 * 18;
    start_b[2] = 8;
    do_reset();
    run(18 + 16, 1, 0, -1, 4'b0100);
    // R8 boundary: last lanes report on edge E+TIMEOUT-1, no request
    start_b[0] = 8;
    for (int l = 1; l < NL; l++) start_b[l] = 4 * (2 + TMO - 1) + l - 1;
    do_reset();
    run(2 + TMO - 1 + 16, 1, 1, -1, 4'b0001);
    // R8 timeout: only lane 1 starts; then R9 realign without reset
    for (int l = 0; l < NL; l++) start_b[l] = -1;
    start_b[1] = 8 + 2;
    do_reset();
    run(2 + TMO + 3, 0, 0, 2, 4'b0010);
    for (int l = 0; l < NL; l++) start_b[l] = 4 * (3 + l * 2) + (3 - l);
    run(9 + 16, 1, 1, -1, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule